// File: doc/BRIEF.md
# Command/Address Parity Gate

This block sits between a host memory controller and the DRAM devices of a registered memory module. It serves two independent sub-channels. On each one it registers the 14-bit command/address word, the two active-low chip selects and the parity bit that the host sends with the word. It checks every qualified word against that parity bit. A command passes to the DRAM-side outputs only when its parity is clean, or always when checking is switched off. A failure pulls an active-low alert output down, in the manner of an open-drain line shared with other devices.

Commands take one or two unit intervals (UIs). A two-UI command is checked in full before any part of it is released, and the output is delayed by a fixed two clock cycles for this reason. The host configures the block with control-word writes, which are commands sent on either sub-channel. These writes go through the same parity check. A sideband-mode entry strobe turns checking on, and the host can turn it off again with a control-word write. Each sub-channel keeps its own sticky error flag. The alert stays low while either flag is set.

Top module: `ca_par_fwd`

## Requirements
- R1: After a synchronous reset, every chip-select output is 2'b11, every CA output is zero, alert_n_o is high and checking is off, so a word with wrong parity is forwarded.
- R2: Parity is even: the 14 CA bits of a UI plus its parity bit must hold an even number of ones. With checking on, a one-UI command with good parity appears on q_ca_o/q_cs_n_o of its sub-channel on the second rising edge after the edge that samples it, unchanged.
- R3: With checking on, a one-UI command with bad parity is dropped. Its output slot shows chip selects 2'b11 and CA zero, and an error is recorded for that sub-channel.
- R4: With checking off, every command is forwarded whatever its parity, and no error is recorded.
- R5: A high sb_mode_enter turns checking on from the next edge. A control-word write to address 0x00 sets checking to bit 0 of its data, and the setting applies to the first command whose first UI is sampled after the write's second UI.
- R6: A word sampled with any chip select low and CA bit 1 equal to 0 starts a two-UI command. The next sampled word is its second UI, whatever its chip selects are. The second UI appears one cycle after the first UI on the outputs.
- R7: With checking on, a two-UI command is dropped in both halves if either half has bad parity, and exactly one error is recorded.
- R8: A control-word write is a two-UI command whose first UI has CA[4:0] = 5'b00101. Its address is CA[12:5] of the first UI and its data is CA[1:0] of the second UI. It is never forwarded. With checking on, a write with bad parity has no effect and records an error.
- R9: Errors and dropped commands on one sub-channel do not change forwarding on the other, even when both sample a command on the same edge.
- R10: An error sets a sticky flag for its sub-channel. alert_n_o goes low on the same edge as the dropped command's output slot and stays low until a control-word write to address 0x01 clears the flag, one bit per sub-channel (bit n clears sub-channel n).
- R11: Every new error holds alert_n_o low for at least 4 cycles, even when its flag is cleared sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling and forwarding |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_mode_enter | input | 1 | Strobe: sideband mode entered, turns checking on |
| ca_i | input | 2x14 | CA word per sub-channel, one UI per cycle |
| par_i | input | 2 | Host parity bit per sub-channel |
| cs_n_i | input | 2x2 | Active-low rank chip selects per sub-channel |
| q_ca_o | output | 2x14 | Forwarded CA word per sub-channel (zero when nothing is forwarded) |
| q_cs_n_o | output | 2x2 | Forwarded chip selects per sub-channel (2'b11 when nothing is forwarded) |
| alert_n_o | output | 1 | Active-low parity alert |

## Verification
The hardest case to reach is a flag clear that lands inside the minimum alert window. A bad command is followed at once, on the same sub-channel, by a control-word clear, so the flag drops one cycle after it was set and only the hold counter keeps the alert low. A second hard case is a change of the checking enable on the very next command. A control-word write on one sub-channel is followed directly by a bad-parity command on the other, once with a clean write and once with a corrupted one, and the outcome tells whether the write took effect.

// File: rtl/ca_par_pkg.sv
// Package: shared constants and types for the CA parity gate.
// Assumes a 14-bit CA word whose low five bits carry the command header.
package ca_par_pkg;

    // Kind of word held in a pipeline stage
    typedef enum logic [1:0] {
        UI_IDLE = 2'd0,
        UI_HEAD = 2'd1,
        UI_TAIL = 2'd2
    } ui_kind_e;

    localparam int          OP_W        = 5;        // header field width
    localparam int          TWO_UI_BIT  = 1;        // 0 here marks a two-UI command
    localparam logic [4:0]  CW_OPCODE   = 5'b00101; // control-word write header
    localparam int          CW_AW       = 8;        // control-word address width
    localparam logic [7:0]  CW_ADDR_EN  = 8'h00;    // checking enable
    localparam logic [7:0]  CW_ADDR_CLR = 8'h01;    // sticky error clear

endpackage

// File: rtl/ca_par_lane.sv
// Module: one sub-channel of the parity gate.
// Three register stages: A samples the bus, B decides, C drives outputs.
// A command header in B sees its second UI in A, so a two-UI command is
// judged whole before release. Assumes CA_W >= OP_W + CW_AW.
module ca_par_lane
    import ca_par_pkg::*;
#(
    parameter int CA_W  = 14,
    parameter int CS_W  = 2,
    parameter int CW_DW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 par_en,
    input  logic [CA_W-1:0]      ca_i,
    input  logic                 par_i,
    input  logic [CS_W-1:0]      cs_n_i,
    output logic [CA_W-1:0]      q_ca_o,
    output logic [CS_W-1:0]      q_cs_n_o,
    output logic                 err_o,
    output logic                 cw_we_o,
    output logic [CW_AW-1:0]     cw_addr_o,
    output logic [CW_DW-1:0]     cw_data_o
);

    // Stage A: raw sample
    logic [CA_W-1:0] a_ca;
    logic            a_par;
    logic [CS_W-1:0] a_cs_n;
    logic            a_is_tail;
    ui_kind_e        a_kind;
    logic            a_bad;
    logic            a_two;

    // Stage B: classified word
    ui_kind_e        b_kind;
    logic [CA_W-1:0] b_ca;
    logic [CS_W-1:0] b_cs_n;
    logic            b_bad;
    logic            b_two;

    // Decision
    logic b_head;
    logic cmd_bad;
    logic b_cw;
    logic keep;
    logic fwd_head;
    logic keep_tail;

    // Classify the word in stage A and test its parity
    always_comb begin
        a_bad  = ^{a_ca, a_par};
        if (a_is_tail)
            a_kind = UI_TAIL;
        else if (a_cs_n != '1)
            a_kind = UI_HEAD;
        else
            a_kind = UI_IDLE;
        a_two  = (a_kind == UI_HEAD) && !a_ca[TWO_UI_BIT];
    end

    // Stage A capture and tail tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ca      <= '0;
            a_par     <= 1'b0;
            a_cs_n    <= '1;
            a_is_tail <= 1'b0;
        end else begin
            a_ca      <= ca_i;
            a_par     <= par_i;
            a_cs_n    <= cs_n_i;
            a_is_tail <= a_two;
        end
    end

    // Stage B capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_kind <= UI_IDLE;
            b_ca   <= '0;
            b_cs_n <= '1;
            b_bad  <= 1'b0;
            b_two  <= 1'b0;
        end else begin
            b_kind <= a_kind;
            b_ca   <= a_ca;
            b_cs_n <= a_cs_n;
            b_bad  <= a_bad;
            b_two  <= a_two;
        end
    end

    // Judge a header in B, using the tail now in A for two-UI commands
    always_comb begin
        b_head    = (b_kind == UI_HEAD);
        cmd_bad   = b_bad | (b_two & a_bad);
        b_cw      = b_head & b_two & (b_ca[OP_W-1:0] == CW_OPCODE);
        keep      = b_head & (!par_en | !cmd_bad);
        fwd_head  = keep & !b_cw;
        err_o     = b_head & par_en & cmd_bad;
        cw_we_o   = keep & b_cw;
        cw_addr_o = b_ca[OP_W +: CW_AW];
        cw_data_o = a_ca[CW_DW-1:0];
    end

    // Stage C: remember the verdict for the tail, drive the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_tail <= 1'b0;
            q_ca_o    <= '0;
            q_cs_n_o  <= '1;
        end else begin
            keep_tail <= fwd_head & b_two;
            unique case (b_kind)
                UI_HEAD: begin
                    q_ca_o   <= fwd_head ? b_ca   : '0;
                    q_cs_n_o <= fwd_head ? b_cs_n : '1;
                end
                UI_TAIL: begin
                    q_ca_o   <= keep_tail ? b_ca   : '0;
                    q_cs_n_o <= keep_tail ? b_cs_n : '1;
                end
                default: begin
                    q_ca_o   <= '0;
                    q_cs_n_o <= '1;
                end
            endcase
        end
    end

    // R3, R7: a failed command with checking on leaves an empty slot
    p_drop_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_kind == UI_HEAD && par_en && cmd_bad) |=> (q_cs_n_o == '1 && q_ca_o == '0));

    // R4: with checking off a normal header is copied through
    p_fwd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_kind == UI_HEAD && !par_en && !b_cw) |=> (q_ca_o == $past(b_ca)));

    // R4: no error is raised while checking is off
    p_err_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> par_en);

    // R6: a tail in B always follows a two-UI header in B
    p_tail_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_kind == UI_TAIL) |-> $past(b_kind == UI_HEAD && b_two));

    // R8: a control-word write never reaches the DRAM side
    p_cw_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_kind == UI_HEAD && b_cw) |=> (q_cs_n_o == '1));

endmodule

// File: rtl/ca_par_ctrl.sv
// Module: shared control for the parity gate.
// Holds the checking enable, one sticky error flag per sub-channel and the
// alert hold counter. Sub-channel 0 wins when both write the enable at once.
module ca_par_ctrl
    import ca_par_pkg::*;
#(
    parameter int NSUB      = 2,
    parameter int ALERT_MIN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sb_mode_enter,
    input  logic [NSUB-1:0]               err_i,
    input  logic [NSUB-1:0]               cw_we_i,
    input  logic [NSUB-1:0][CW_AW-1:0]    cw_addr_i,
    input  logic [NSUB-1:0][NSUB-1:0]     cw_data_i,
    output logic                          par_en_o,
    output logic                          alert_n_o
);

    localparam int CNT_W = $clog2(ALERT_MIN + 1);

    logic            en_wr;
    logic            en_val;
    logic [NSUB-1:0] clr_mask;
    logic [NSUB-1:0] sticky;
    logic [CNT_W-1:0] hold_cnt;

    // Gather control-word writes from all sub-channels
    always_comb begin
        en_wr    = 1'b0;
        en_val   = 1'b0;
        clr_mask = '0;
        for (int i = NSUB - 1; i >= 0; i--) begin
            if (cw_we_i[i] && cw_addr_i[i] == CW_ADDR_EN) begin
                en_wr  = 1'b1;
                en_val = cw_data_i[i][0];
            end
            if (cw_we_i[i] && cw_addr_i[i] == CW_ADDR_CLR)
                clr_mask = clr_mask | cw_data_i[i];
        end
    end

    // Checking enable: sideband entry first, then control writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            par_en_o <= 1'b0;
        else if (sb_mode_enter)
            par_en_o <= 1'b1;
        else if (en_wr)
            par_en_o <= en_val;
    end

    // Sticky error flags: a new error beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky <= '0;
        else
            sticky <= (sticky & ~clr_mask) | err_i;
    end

    // Minimum alert hold, reloaded by every new error
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (|err_i)
            hold_cnt <= CNT_W'(ALERT_MIN);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    // Alert output
    assign alert_n_o = !((|sticky) || (hold_cnt != '0));

    // R10: any error pulls the alert low on the next edge
    p_err_alerts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> !alert_n_o);

    // R11: a falling alert is never a single-cycle glitch
    p_alert_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n_o) |=> !alert_n_o);

    // R5: sideband entry always leaves checking on
    p_sb_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sb_mode_enter |=> par_en_o);

    // R10: with no error and no clear the flags do not move
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i == '0 && clr_mask == '0) |=> $stable(sticky));

endmodule

// File: rtl/ca_par_fwd.sv
// Module: top of the CA parity gate.
// One lane per sub-channel, built by generate, plus the shared control.
// Assumes NSUB sub-channels, each with CS_W rank selects.
module ca_par_fwd
    import ca_par_pkg::*;
#(
    parameter int NSUB      = 2,
    parameter int CA_W      = 14,
    parameter int CS_W      = 2,
    parameter int ALERT_MIN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sb_mode_enter,
    input  logic [NSUB-1:0][CA_W-1:0]    ca_i,
    input  logic [NSUB-1:0]              par_i,
    input  logic [NSUB-1:0][CS_W-1:0]    cs_n_i,
    output logic [NSUB-1:0][CA_W-1:0]    q_ca_o,
    output logic [NSUB-1:0][CS_W-1:0]    q_cs_n_o,
    output logic                         alert_n_o
);

    logic                        par_en;
    logic [NSUB-1:0]             err;
    logic [NSUB-1:0]             cw_we;
    logic [NSUB-1:0][CW_AW-1:0]  cw_addr;
    logic [NSUB-1:0][NSUB-1:0]   cw_data;

    // One checking lane per sub-channel
    for (genvar g = 0; g < NSUB; g++) begin : g_lane
        ca_par_lane #(
            .CA_W  (CA_W),
            .CS_W  (CS_W),
            .CW_DW (NSUB)
        ) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .par_en    (par_en),
            .ca_i      (ca_i[g]),
            .par_i     (par_i[g]),
            .cs_n_i    (cs_n_i[g]),
            .q_ca_o    (q_ca_o[g]),
            .q_cs_n_o  (q_cs_n_o[g]),
            .err_o     (err[g]),
            .cw_we_o   (cw_we[g]),
            .cw_addr_o (cw_addr[g]),
            .cw_data_o (cw_data[g])
        );
    end

    // Shared enable, error flags and alert
    ca_par_ctrl #(
        .NSUB      (NSUB),
        .ALERT_MIN (ALERT_MIN)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sb_mode_enter (sb_mode_enter),
        .err_i         (err),
        .cw_we_i       (cw_we),
        .cw_addr_i     (cw_addr),
        .cw_data_i     (cw_data),
        .par_en_o      (par_en),
        .alert_n_o     (alert_n_o)
    );

endmodule

// File: tb/ca_par_fwd_tb_top.sv
// Bench: vector table of isolated commands, then directed tests for the
// enable, control writes, alert timing and sub-channel independence.
module ca_par_fwd_tb_top;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sb_mode_enter = 1'b0;
    logic [1:0][13:0]     ca_i = '0;
    logic [1:0]           par_i = '0;
    logic [1:0][1:0]      cs_n_i = '1;
    logic [1:0][13:0]     q_ca_o;
    logic [1:0][1:0]      q_cs_n_o;
    logic                 alert_n_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    ca_par_fwd dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sb_mode_enter (sb_mode_enter),
        .ca_i          (ca_i),
        .par_i         (par_i),
        .cs_n_i        (cs_n_i),
        .q_ca_o        (q_ca_o),
        .q_cs_n_o      (q_cs_n_o),
        .alert_n_o     (alert_n_o)
    );

    typedef struct packed {
        logic        lane;
        logic        en;
        logic        two;
        logic [1:0]  cs;
        logic        bad0;
        logic        bad1;
        logic        exp_fwd;
        logic        exp_err;
        logic [13:0] ca0;
        logic [13:0] ca1;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0A5A, 14'h0000},
        '{1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 14'h3FFF, 14'h0000},
        '{1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 14'h1236, 14'h0000},
        '{1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 14'h2002, 14'h0000},
        '{1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0C58, 14'h1357},
        '{1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 14'h0004, 14'h2AAA},
        '{1'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 14'h3F10, 14'h0FF0},
        '{1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 14'h0010, 14'h1FFF},
        '{1'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0020, 14'h0001},
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0003, 14'h0000}
    };

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_err = n_err + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: all requirements, actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one UI on a sub-channel; bad=1 sends the wrong parity
    task automatic put(input int ln, input logic [13:0] ca, input logic [1:0] cs, input logic bad);
        ca_i[ln]   = ca;
        cs_n_i[ln] = cs;
        par_i[ln]  = (^ca) ^ bad;
    endtask

    task automatic idle(input int ln);
        ca_i[ln]   = '0;
        cs_n_i[ln] = 2'b11;
        par_i[ln]  = 1'b0;
    endtask

    function automatic logic [13:0] cw_head(input logic [7:0] addr);
        return {1'b0, addr, 5'b00101};
    endfunction

    task automatic do_reset;
        rst_n = 1'b0;
        sb_mode_enter = 1'b0;
        idle(0);
        idle(1);
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic sb_pulse;
        tick();
        sb_mode_enter = 1'b1;
        tick();
        sb_mode_enter = 1'b0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 cs_n lane0", 32'(q_cs_n_o[0]), 32'h3);
        chk("R1 cs_n lane1", 32'(q_cs_n_o[1]), 32'h3);
        chk("R1 ca lane0",   32'(q_ca_o[0]), 32'h0);
        chk("R1 alert",      32'(alert_n_o), 32'h1);
        // R1: checking off after reset, bad word still forwarded
        tick(); put(0, 14'h0106, 2'b10, 1'b1);
        tick(); idle(0);
        tick(); tick();
        chk("R1 off fwd ca", 32'(q_ca_o[0]), 32'h0106);
        chk("R1 off alert",  32'(alert_n_o), 32'h1);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            vec_t  t;
            string tag;
            int    ln;
            int    ot;
            t  = VEC[v];
            ln = int'(t.lane);
            ot = 1 - ln;
            if (!t.en)            tag = "R4";
            else if (t.two)       tag = "R7";
            else if (t.exp_fwd)   tag = "R2";
            else                  tag = "R3";
            do_reset();
            if (t.en) sb_pulse();
            tick(); put(ln, t.ca0, t.cs, t.bad0);
            tick();
            if (t.two) put(ln, t.ca1, 2'b11, t.bad1);
            else       idle(ln);
            tick(); idle(ln);
            tick();
            chk({tag, " head ca"},   32'(q_ca_o[ln]),   t.exp_fwd ? 32'(t.ca0) : 32'h0);
            chk({tag, " head cs_n"}, 32'(q_cs_n_o[ln]), t.exp_fwd ? 32'(t.cs)  : 32'h3);
            chk({tag, " alert"},     32'(alert_n_o),    32'(!t.exp_err));
            chk("R9 other idle",     32'(q_cs_n_o[ot]), 32'h3);
            tick();
            chk(t.two ? "R6 tail ca" : "R6 no tail", 32'(q_ca_o[ln]),
                (t.two && t.exp_fwd) ? 32'(t.ca1) : 32'h0);
        end

        // R5, R8: clean control write turns checking off for the next command
        do_reset(); sb_pulse();
        tick(); put(0, cw_head(8'h00), 2'b10, 1'b0);
        tick(); put(0, 14'h0000, 2'b11, 1'b0);
        tick(); idle(0); put(1, 14'h0102, 2'b10, 1'b1);
        tick(); idle(1);
        chk("R8 cw not fwd head", 32'(q_cs_n_o[0]), 32'h3);
        tick();
        chk("R8 cw not fwd tail", 32'(q_cs_n_o[0]), 32'h3);
        tick();
        chk("R5 off next cmd ca",   32'(q_ca_o[1]),   32'h0102);
        chk("R5 off next cmd cs_n", 32'(q_cs_n_o[1]), 32'h2);
        chk("R5 off no alert",      32'(alert_n_o),   32'h1);

        // R8: corrupted control write is ignored and flagged
        do_reset(); sb_pulse();
        tick(); put(0, cw_head(8'h00), 2'b10, 1'b0);
        tick(); put(0, 14'h0000, 2'b11, 1'b1);
        tick(); idle(0); put(1, 14'h0102, 2'b10, 1'b1);
        tick(); idle(1);
        chk("R8 bad cw alert", 32'(alert_n_o), 32'h0);
        tick(); tick();
        chk("R8 bad cw ignored, cmd dropped", 32'(q_cs_n_o[1]), 32'h3);

        // R5: control write turns checking on (accepted even with bad parity while off)
        do_reset();
        tick(); put(1, cw_head(8'h00), 2'b01, 1'b0);
        tick(); put(1, 14'h0001, 2'b11, 1'b1);
        tick(); idle(1); put(0, 14'h0006, 2'b10, 1'b1);
        tick(); idle(0);
        tick(); tick();
        chk("R5 on drops bad", 32'(q_cs_n_o[0]), 32'h3);
        chk("R5 on alert",     32'(alert_n_o),   32'h0);

        // R11: early clear still leaves a 4-cycle alert
        do_reset(); sb_pulse();
        tick(); put(0, 14'h0042, 2'b10, 1'b1);
        tick(); put(0, cw_head(8'h01), 2'b10, 1'b0);
        tick(); put(0, 14'h0001, 2'b11, 1'b0);
        tick(); idle(0);
        chk("R11 alert c0", 32'(alert_n_o), 32'h0);
        chk("R3 dropped",   32'(q_cs_n_o[0]), 32'h3);
        tick(); chk("R11 alert c1", 32'(alert_n_o), 32'h0);
        tick(); chk("R11 alert c2", 32'(alert_n_o), 32'h0);
        tick(); chk("R11 alert c3", 32'(alert_n_o), 32'h0);
        tick(); chk("R11 alert released", 32'(alert_n_o), 32'h1);

        // R10: sticky until the right bit is cleared
        do_reset(); sb_pulse();
        tick(); put(1, 14'h1003, 2'b01, 1'b1);
        tick(); idle(1);
        repeat (20) tick();
        chk("R10 still low", 32'(alert_n_o), 32'h0);
        tick(); put(0, cw_head(8'h01), 2'b10, 1'b0);
        tick(); put(0, 14'h0001, 2'b11, 1'b0);
        tick(); idle(0);
        repeat (6) tick();
        chk("R10 wrong bit keeps low", 32'(alert_n_o), 32'h0);
        tick(); put(0, cw_head(8'h01), 2'b10, 1'b0);
        tick(); put(0, 14'h0002, 2'b11, 1'b0);
        tick(); idle(0);
        repeat (6) tick();
        chk("R10 cleared high", 32'(alert_n_o), 32'h1);

        // R9: same-edge error on lane 0, good two-UI on lane 1
        do_reset(); sb_pulse();
        tick(); put(0, 14'h0F0F, 2'b10, 1'b1); put(1, 14'h0A00, 2'b01, 1'b0);
        tick(); idle(0); put(1, 14'h1555, 2'b11, 1'b0);
        tick(); idle(1);
        tick();
        chk("R9 lane0 dropped",  32'(q_cs_n_o[0]), 32'h3);
        chk("R9 lane1 head ca",  32'(q_ca_o[1]),   32'h0A00);
        chk("R9 lane1 head cs",  32'(q_cs_n_o[1]), 32'h1);
        tick();
        chk("R9 lane1 tail ca",  32'(q_ca_o[1]),   32'h1555);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule